// File: doc/BRIEF.md
# Event-Flag UART Peripheral

This block is a small memory-mapped serial port. Software reaches five 32-bit word registers over a simple single-beat bus: received/transmit data, bit-period divisor, status, control and debug. Writing the data register while the transmitter is idle launches one 8N1 frame, least significant bit first, on the serial output. A frame arriving on the serial input is kept in a one-byte holding register until software acknowledges it.

Two sticky event flags report activity. The receive flag is set when a byte is captured. The transmit flag is set when a frame's stop bit has been fully sent. Software clears either flag by writing a one to its status bit. A single level interrupt line is raised whenever a set flag has its enable bit set in the control register. While the receive flag is set, any newly completed byte is dropped, so the held byte cannot be overwritten before it is acknowledged.

The bus has no back-pressure. Every access completes in the cycle it is presented: `bus_valid` qualifies it and `bus_write` selects a write. Inside the block, the receiver hands each completed byte to the register file as a one-cycle valid pulse. The register file accepts the pulse only when its holding register is free and otherwise discards it. The transmitter likewise takes a byte only when it is idle.

Top module: `evt_uart`

## Requirements
- R1: Registers sit at byte addresses 0x00 (data), 0x04 (divisor), 0x08 (status), 0x0C (control) and 0x10 (debug). Any other address, including one with bits [1:0] not zero, is unmapped: a write to it changes nothing and a read of it returns 0. `bus_rdata` is 0 whenever no read is presented.
- R2: After reset the divisor, control, debug, held byte and both event flags are 0, and the status register reads 0x1. Status bit 0, the transmitter-empty bit, always reads 1.
- R3: The divisor stores the low DIV_W bits of the written word. Control stores bits [2:0]: bit 0 is the receive interrupt enable, bit 1 is the transmit interrupt enable, and bit 2 is a pass-through bit that is only stored. Debug stores bit 0, a break bit that is only stored. All other bits of these registers read 0.
- R4: A data write while the transmitter is idle sends wdata[7:0] as one frame: a start bit of 0, eight data bits LSB first, then a stop bit of 1. Each bit lasts P cycles, where P is the divisor or 1 if the divisor is 0. The start bit appears on `txd` in the cycle after the write, and the line idles at 1.
- R5: A data write made while a frame is still being sent has no effect.
- R6: The transmit event flag (status bit 2) is set at the clock edge that ends the stop bit, 10*P cycles after the write edge. Writing status with bit 1 or bit 2 at 1 clears the matching flag. A flag being set in the same cycle as a clear of it stays set. Writing status bit 0 has no effect.
- R7: `irq` is 1 exactly when (status bit 1 AND control bit 0) OR (status bit 2 AND control bit 1), and follows register updates with no added delay.
- R8: The receiver detects a start-bit falling edge, samples each bit at mid-bit with period P, and then captures the byte into the holding register, sets the receive event flag (status bit 1), and reads the byte back at the data address in bits [7:0].
- R9: A byte that completes while the receive event flag is set is discarded, and the held byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
The bench builds the block with DIV_W of 8 and ADDR_W of 8. With a narrow divisor, a single write with bit 8 set shows that the upper bits are dropped. The 8-bit address reaches both the unmapped words above the debug register and the misaligned byte addresses. Bit periods of 4 and 0 (treated as 1) keep frames short, so the stop-bit timing of the transmit flag, writes issued mid-frame, and a byte arriving while one is already held all fit into a short run.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;
  localparam int unsigned IDX_DATA   = 0;
  localparam int unsigned IDX_DIV    = 1;
  localparam int unsigned IDX_STAT   = 2;
  localparam int unsigned IDX_CTRL   = 3;
  localparam int unsigned IDX_DBG    = 4;
  localparam int unsigned ST_EMPTY   = 0;
  localparam int unsigned ST_RXEV    = 1;
  localparam int unsigned ST_TXEV    = 2;
  localparam int unsigned CT_RXIE    = 0;
  localparam int unsigned CT_TXIE    = 1;
  localparam int unsigned CTRL_BITS  = 3;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/evt_uart_tx.sv
module evt_uart_tx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             busy,
  output logic             done,
  output logic             txd
);
  import evt_uart_pkg::*;
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shift_q;
  logic [DIV_W-1:0]      cnt_q, per_q;
  logic [3:0]            bitn_q;
  logic                  bit_end;

  assign bit_end = busy && (cnt_q == per_q - 1'b1);
  assign done    = bit_end && (bitn_q == LAST_BIT);
  assign txd     = busy ? shift_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shift_q <= '1;
      cnt_q   <= '0;
      per_q   <= DIV_W'(1);
      bitn_q  <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy    <= 1'b1;
        shift_q <= {1'b1, in_data, 1'b0};
        cnt_q   <= '0;
        bitn_q  <= '0;
        per_q   <= (div == '0) ? DIV_W'(1) : div;
      end
    end else if (bit_end) begin
      cnt_q   <= '0;
      shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
      if (bitn_q == LAST_BIT) busy <= 1'b0;
      else                    bitn_q <= bitn_q + 4'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  import evt_uart_pkg::*;

  rx_state_e        state_q;
  logic             s1_q, s2_q;
  logic [DIV_W-1:0] cnt_q, per_q;
  logic [2:0]       bitn_q;
  logic [7:0]       sh_q;
  logic             bit_end;

  assign bit_end = (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      per_q     <= DIV_W'(1);
      bitn_q    <= '0;
      sh_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (!s2_q) begin
            state_q <= RX_START;
            cnt_q   <= '0;
            per_q   <= (div == '0) ? DIV_W'(1) : div;
          end
        end
        RX_START: begin
          if (cnt_q == (per_q >> 1)) begin
            cnt_q   <= '0;
            bitn_q  <= '0;
            state_q <= s2_q ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[7:1]};
            if (bitn_q == 3'd7) state_q <= RX_STOP;
            else                bitn_q  <= bitn_q + 3'd1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (bit_end) begin
            out_valid <= 1'b1;
            out_data  <= sh_q;
            state_q   <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/evt_uart_regs.sv
module evt_uart_regs #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [DIV_W-1:0]  div,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_done,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data
);
  import evt_uart_pkg::*;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [CTRL_BITS-1:0] ctrl_q;
  logic                 dbg_q;
  logic                 rx_evt_q, tx_evt_q;
  logic [7:0]           hold_q;
  logic [IDX_W-1:0]     idx;
  logic                 aligned, wr, rd;
  logic [4:0]           hit;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_valid && bus_write && aligned;
  assign rd      = bus_valid && !bus_write && aligned;

  for (genvar g = 0; g < 5; g++) begin : g_hit
    assign hit[g] = (idx == IDX_W'(g));
  end

  assign tx_valid = wr && hit[IDX_DATA];
  assign tx_data  = bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div      <= '0;
      ctrl_q   <= '0;
      dbg_q    <= 1'b0;
      rx_evt_q <= 1'b0;
      tx_evt_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      if (wr && hit[IDX_DIV])  div    <= bus_wdata[DIV_W-1:0];
      if (wr && hit[IDX_CTRL]) ctrl_q <= bus_wdata[CTRL_BITS-1:0];
      if (wr && hit[IDX_DBG])  dbg_q  <= bus_wdata[0];

      if (tx_done) tx_evt_q <= 1'b1;
      else if (wr && hit[IDX_STAT] && bus_wdata[ST_TXEV]) tx_evt_q <= 1'b0;

      if (rx_valid && !rx_evt_q) begin
        rx_evt_q <= 1'b1;
        hold_q   <= rx_data;
      end else if (wr && hit[IDX_STAT] && bus_wdata[ST_RXEV]) begin
        rx_evt_q <= 1'b0;
      end
    end
  end

  assign irq = (rx_evt_q && ctrl_q[CT_RXIE]) || (tx_evt_q && ctrl_q[CT_TXIE]);

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit[IDX_DATA]) bus_rdata[7:0] = hold_q;
      if (hit[IDX_DIV])  bus_rdata[DIV_W-1:0] = div;
      if (hit[IDX_STAT]) begin
        bus_rdata[ST_EMPTY] = 1'b1;
        bus_rdata[ST_RXEV]  = rx_evt_q;
        bus_rdata[ST_TXEV]  = tx_evt_q;
      end
      if (hit[IDX_CTRL]) bus_rdata[CTRL_BITS-1:0] = ctrl_q;
      if (hit[IDX_DBG])  bus_rdata[0] = dbg_q;
    end
  end
endmodule

// File: rtl/evt_uart.sv
module evt_uart #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              txd,
  input  logic              rxd
);
  logic [DIV_W-1:0] div;
  logic             tx_valid, tx_done, tx_busy, rx_valid;
  logic [7:0]       tx_data, rx_data;

  evt_uart_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .div(div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  evt_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div), .in_valid(tx_valid),
    .in_data(tx_data), .busy(tx_busy), .done(tx_done), .txd(txd)
  );

  evt_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div), .rxd(rxd),
    .out_valid(rx_valid), .out_data(rx_data)
  );
endmodule

// File: rtl/evt_uart_chk.sv
module evt_uart_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              txd,
  input logic              tx_busy,
  input logic              tx_evt,
  input logic              rx_evt,
  input logic [7:0]        hold,
  input logic [2:0]        ctrl
);
  logic rd_any, unmapped;
  assign rd_any   = bus_valid && !bus_write;
  assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr >= ADDR_W'(20));

  // R1
  no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |-> (bus_rdata == 32'd0));
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && unmapped) |-> (bus_rdata == 32'd0));
  // R2
  empty_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && bus_addr == ADDR_W'(8)) |-> bus_rdata[0]);
  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R6
  txevt_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_evt) |-> ($past(tx_busy) && !tx_busy));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[1]) |-> !irq);
  // R9
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_evt) && rx_evt) |-> $stable(hold));
endmodule

bind evt_uart evt_uart_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .txd(txd),
  .tx_busy(u_tx.busy), .tx_evt(u_regs.tx_evt_q), .rx_evt(u_regs.rx_evt_q),
  .hold(u_regs.hold_q), .ctrl(u_regs.ctrl_q)
);

// File: tb/test_evt_uart.sv
`timescale 1ns/1ps
module test_evt_uart;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq, txd;
  logic          rxd = 1'b1;

  int errors = 0, checks = 0;
  bit done_flag = 0;

  evt_uart #(.ADDR_W(AW), .DIV_W(DW)) i_evt_uart (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd)
  );

  always #2 clk = ~clk;

  // behavioural reference state
  int   m_div, m_ctrl, m_dbg, m_rxe, m_txe, m_hold;
  int   tx_left, tx_p, tx_byte;
  bit   rx_win = 0;

  function automatic int per_of(int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic bit m_line();
    int b;
    if (tx_left == 0) return 1'b1;
    b = (10 * tx_p - tx_left) / tx_p;
    if (b == 0) return 1'b0;
    if (b <= 8) return tx_byte[b-1];
    return 1'b1;
  endfunction

  function automatic int m_read();
    int idx;
    if (!bus_valid || bus_write || bus_addr[1:0] != 0) return 0;
    idx = bus_addr >> 2;
    case (idx)
      0: return m_hold;
      1: return m_div;
      2: return 1 | (m_rxe << 1) | (m_txe << 2);
      3: return m_ctrl;
      4: return m_dbg;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_ctrl = 0; m_dbg = 0; m_rxe = 0; m_txe = 0; m_hold = 0;
      tx_left = 0; tx_p = 1; tx_byte = 0;
    end else begin
      bit was_busy, fin;
      was_busy = (tx_left > 0);
      fin = (tx_left == 1);
      if (tx_left > 0) tx_left--;
      if (bus_valid && bus_write && bus_addr[1:0] == 0) begin
        case (int'(bus_addr >> 2))
          0: if (!was_busy) begin
               tx_p = per_of(m_div); tx_left = 10 * tx_p; tx_byte = bus_wdata[7:0];
             end
          1: m_div = bus_wdata[DW-1:0];
          2: begin
               if (bus_wdata[1]) m_rxe = 0;
               if (bus_wdata[2]) m_txe = 0;
             end
          3: m_ctrl = bus_wdata[2:0];
          4: m_dbg = bus_wdata[0];
          default: ;
        endcase
      end
      if (fin) m_txe = 1;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done_flag) begin
      int exp_rd, got_rd;
      bit exp_irq;
      checks++;
      if (txd !== m_line()) begin
        errors++; $display("FAIL R4 txd got %0b exp %0b at %0t", txd, m_line(), $time);
      end
      exp_irq = (m_rxe && m_ctrl[0]) || (m_txe && m_ctrl[1]);
      if (!rx_win) begin
        checks++;
        if (irq !== exp_irq) begin
          errors++; $display("FAIL R7 irq got %0b exp %0b at %0t", irq, exp_irq, $time);
        end
      end
      exp_rd = m_read(); got_rd = bus_rdata;
      if (rx_win) begin exp_rd = exp_rd & ~2; got_rd = got_rd & ~2; end
      checks++;
      if (got_rd !== exp_rd) begin
        errors++; $display("FAIL R1 rdata got %h exp %h at %0t", got_rd, exp_rd, $time);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a[AW-1:0];
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      errors++; $display("FAIL %s read %h got %h exp %h", tag, a, bus_rdata, exp);
    end
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic check_irq(bit exp, string tag);
    @(negedge clk); #1;
    checks++;
    if (irq !== exp) begin
      errors++; $display("FAIL %s irq got %0b exp %0b", tag, irq, exp);
    end
  endtask

  task automatic send_rx(int b, int p);
    rx_win = 1;
    @(negedge clk);
    rxd = 0; idle(p);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; idle(p); end
    rxd = 1; idle(p + 3 * p + 4);
    if (m_rxe == 0) begin m_rxe = 1; m_hold = b & 8'hff; end
    rx_win = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done_flag) begin
      done_flag = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 checks++;
    if (txd !== 1'b1 || irq !== 1'b0) begin
      errors++; $display("FAIL R2 reset txd/irq got %0b/%0b exp 1/0", txd, irq);
    end
    rst_n = 1;
    idle(2);
    // R2 reset values
    rd(8'h08, 1, "R2");
    rd(8'h00, 0, "R2");
    rd(8'h04, 0, "R2");
    rd(8'h0C, 0, "R2");
    // R3 storage widths
    wr(8'h04, 32'h0000_0104);
    rd(8'h04, 4, "R3");
    wr(8'h0C, 32'hFFFF_FFF4);
    rd(8'h0C, 4, "R3");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 1, "R3");
    // R1 unmapped and misaligned
    wr(8'h14, 32'h3);
    wr(8'h0D, 32'h3);
    rd(8'h0C, 4, "R1");
    rd(8'h14, 0, "R1");
    rd(8'h0E, 0, "R1");
    rd(8'hFC, 0, "R1");
    // R4 / R5 / R6 transmit with period 4
    wr(8'h0C, 32'h2);
    wr(8'h00, 32'hA5);
    idle(8);
    wr(8'h00, 32'h5A);           // R5: mid-frame write ignored
    idle(34);
    rd(8'h08, 5, "R6");
    check_irq(1, "R7");
    wr(8'h08, 32'h1);            // R6: bit 0 write has no effect
    rd(8'h08, 5, "R6");
    wr(8'h08, 32'h4);
    rd(8'h08, 1, "R6");
    check_irq(0, "R7");
    // R4 with divisor 0 -> one-cycle bits
    wr(8'h04, 0);
    wr(8'h00, 32'h3C);
    idle(12);
    rd(8'h08, 5, "R6");
    wr(8'h08, 32'h6);
    // R8 receive
    wr(8'h04, 4);
    wr(8'h0C, 32'h1);
    send_rx(8'h3C, 4);
    rd(8'h00, 32'h3C, "R8");
    rd(8'h08, 3, "R8");
    check_irq(1, "R7");
    // R9 second byte dropped while flag set
    send_rx(8'hE7, 4);
    rd(8'h00, 32'h3C, "R9");
    wr(8'h08, 32'h2);
    rd(8'h08, 1, "R8");
    check_irq(0, "R7");
    send_rx(8'hC3, 4);
    rd(8'h00, 32'hC3, "R8");
    idle(4);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule